// File: doc/BRIEF.md
# Memory-Type Range Register File

This block stores the settings that assign a caching type to regions of physical memory. It holds one default-type register, eleven fixed-range registers of eight type bytes each, and `NUM_VAR` pairs of variable base/mask registers. It also has a read-only capability register. Software reaches all of them through a simple register port: an index, 64-bit write data, and write and read strobes.

Every write is checked against the rules for its register class. These rules cover the set of legal type codes, the bits that must stay clear, and the bits above the configured physical address width. A write that breaks a rule raises `err` in the same cycle and changes no state. Reads return the stored value combinationally. For mask registers, the bits above the physical width are cleared on the way out.

The decoded state drives a downstream lookup block directly: the global and fixed enables, the default type, all fixed type bytes, and the stored bases, masks and valid flags.

Top module: `mtr_regfile`

## Requirements
- R1: A type code is legal only when it is 0, 1, 4, 5 or 6. Codes 2, 3, 7 and anything of 8 or above are refused wherever a type field is checked.
- R2: Index 1 is the default-type register. Bit 11 drives `mt_enable`, bit 10 drives `fixed_enable`, and bits 7:0 drive `default_type`. A write with any bit set outside 0xCFF, or with an illegal type, is refused.
- R3: Indices 2 to 12 are fixed-range registers 0 to 10, exposed on `fixed_types[k*64 +: 64]`. A write is accepted only when all eight bytes hold legal codes.
- R4: Variable registers start at index 16. An even index is the base of pair (index-16)/2, and the following odd index is that pair's mask.
- R5: A base write must carry a legal type in bits 7:0 and zeros in bits 11:8.
- R6: A mask write must have bits 10:0 at zero. Bit 11 of the stored mask appears on `var_valid` for that pair.
- R7: Base and mask writes with any bit at or above `PA_BITS` set are refused.
- R8: Index 0 reads 0x500 OR `NUM_VAR`. A write to it is refused.
- R9: A stored mask has every bit at or above `PA_BITS` forced to one, as seen on `var_mask`. Those bits read back as zero.
- R10: A refused write raises `err` in its own cycle and leaves every register unchanged.
- R11: After reset every register is zero. A read or write to an unmapped index raises `err`, and `rdata` is zero whenever `rd_en` is low or the index is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | IDX_W | Register index |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational |
| err | output | 1 | Access refused or index unmapped |
| mt_enable | output | 1 | Global enable |
| fixed_enable | output | 1 | Fixed-range enable |
| default_type | output | 8 | Default type code |
| fixed_types | output | 704 | Eleven fixed registers, concatenated |
| var_base | output | NUM_VAR*64 | Stored bases, concatenated |
| var_mask | output | NUM_VAR*64 | Stored masks, with high bits forced to one |
| var_valid | output | NUM_VAR | Valid flag per pair |

## Verification
Writes are driven for each register class, using data that is legal in one lane or field and illegal in exactly one other place. This separates a per-byte check in a fixed register from a check that covers only the low byte, and separates the 11:8 rule from the type rule in base writes. Address-width probes set bit `PA_BITS` or a bit just below it, so an off-by-one in the reserved mask shows up. Mask writes are read back to tell the stored form apart from the returned form. Unmapped indices in the gaps and past the last pair are tested, along with both ends of the variable range.

// File: rtl/mtr_regfile.sv
module mtr_regfile #(
  parameter int NUM_VAR = 8,
  parameter int PA_BITS = 40,
  parameter int IDX_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       addr,
  input  logic [63:0]            wdata,
  output logic [63:0]            rdata,
  output logic                   err,
  output logic                   mt_enable,
  output logic                   fixed_enable,
  output logic [7:0]             default_type,
  output logic [11*64-1:0]       fixed_types,
  output logic [NUM_VAR*64-1:0]  var_base,
  output logic [NUM_VAR*64-1:0]  var_mask,
  output logic [NUM_VAR-1:0]     var_valid
);

  localparam int          FIX_N  = 11;
  localparam int          FIX_LO = 2;
  localparam int          VAR_LO = 16;
  localparam int          VAR_HI = VAR_LO + 2 * NUM_VAR;
  localparam int          PW     = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
  localparam logic [63:0] LOW    = (64'd1 << PA_BITS) - 64'd1;
  localparam logic [63:0] RESV   = ~LOW;
  localparam logic [63:0] CAP    = 64'h500 | 64'(NUM_VAR);

  function automatic logic ok_type(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  logic [63:0] def_q;
  logic [63:0] fix_q  [FIX_N];
  logic [63:0] base_q [NUM_VAR];
  logic [63:0] mask_q [NUM_VAR];

  int          a;
  logic        is_cap, is_def, is_fix, is_var, is_mask, known, bad, fix_ok, accept;
  logic [3:0]  fsel;
  logic [PW-1:0] psel;

  assign a       = int'(addr);
  assign is_cap  = (a == 0);
  assign is_def  = (a == 1);
  assign is_fix  = (a >= FIX_LO) && (a < FIX_LO + FIX_N);
  assign is_var  = (a >= VAR_LO) && (a < VAR_HI);
  assign is_mask = addr[0];
  assign known   = is_cap | is_def | is_fix | is_var;
  assign fsel    = 4'(a - FIX_LO);
  assign psel    = PW'((a - VAR_LO) >> 1);

  always_comb begin
    fix_ok = 1'b1;
    for (int b = 0; b < 8; b++)
      if (!ok_type(wdata[b*8 +: 8])) fix_ok = 1'b0;
  end

  always_comb begin
    bad = 1'b0;
    if (is_cap)      bad = 1'b1;
    else if (is_def) bad = (|(wdata & ~64'hCFF)) || !ok_type(wdata[7:0]);
    else if (is_fix) bad = !fix_ok;
    else if (is_var) begin
      if (is_mask) bad = (|wdata[10:0]) || (|(wdata & RESV));
      else         bad = !ok_type(wdata[7:0]) || (|wdata[11:8]) || (|(wdata & RESV));
    end
  end

  assign accept = wr_en && known && !bad;
  assign err    = ((wr_en || rd_en) && !known) || (wr_en && known && bad);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (is_cap)      rdata = CAP;
      else if (is_def) rdata = def_q;
      else if (is_fix) rdata = fix_q[fsel];
      else if (is_var) rdata = (is_mask ? mask_q[psel] : base_q[psel]) & LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      def_q <= '0;
      for (int i = 0; i < FIX_N; i++)   fix_q[i]  <= '0;
      for (int i = 0; i < NUM_VAR; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (accept) begin
      if (is_def)       def_q       <= wdata;
      else if (is_fix)  fix_q[fsel] <= wdata;
      else if (is_var) begin
        if (is_mask) mask_q[psel] <= wdata | RESV;
        else         base_q[psel] <= wdata;
      end
    end
  end

  assign mt_enable    = def_q[11];
  assign fixed_enable = def_q[10];
  assign default_type = def_q[7:0];

  for (genvar k = 0; k < FIX_N; k++) begin : g_fix
    assign fixed_types[k*64 +: 64] = fix_q[k];
    for (genvar b = 0; b < 8; b++) begin : g_lane
      assert_fix_lane_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok_type(fix_q[k][b*8 +: 8]));
    end
  end

  for (genvar p = 0; p < NUM_VAR; p++) begin : g_var
    assign var_base[p*64 +: 64] = base_q[p];
    assign var_mask[p*64 +: 64] = mask_q[p];
    assign var_valid[p]         = mask_q[p][11];
    assert_mask_high_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      var_valid[p] |-> ((var_mask[p*64 +: 64] & RESV) == RESV));
    assert_base_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (var_base[p*64 + 8 +: 4] == 4'd0) && ok_type(var_base[p*64 +: 8]));
  end

  assert_default_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ok_type(default_type));
  assert_refused_keeps_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && err) |=> $stable(def_q));
  assert_cap_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |-> err);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !known) |-> (err && rdata == '0));

endmodule

// File: tb/test_mtr_regfile.sv
module test_mtr_regfile;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam int PA    = 40;
  localparam logic [63:0] LOWM = (64'd1 << PA) - 64'd1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        err, mt_enable, fixed_enable;
  logic [7:0]  default_type;
  logic [703:0] fixed_types;
  logic [NV*64-1:0] var_base, var_mask;
  logic [NV-1:0] var_valid;

  mtr_regfile #(.NUM_VAR(NV), .PA_BITS(PA), .IDX_W(6)) i_mtr_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .mt_enable(mt_enable),
    .fixed_enable(fixed_enable), .default_type(default_type),
    .fixed_types(fixed_types), .var_base(var_base), .var_mask(var_mask),
    .var_valid(var_valid));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit live = 0;
  logic [63:0] m_def;
  logic [63:0] m_fix [11];
  logic [63:0] m_base [NV];
  logic [63:0] m_mask [NV];

  function automatic bit legal(logic [7:0] t);
    return t == 0 || t == 1 || t == 4 || t == 5 || t == 6;
  endfunction

  function automatic bit mapped(int x);
    return x <= 12 || (x >= 16 && x < 16 + 2*NV);
  endfunction

  function automatic bit refused(int x, logic [63:0] d);
    if (x == 0) return 1;
    if (x == 1) return (d & ~64'hCFF) != 0 || !legal(d[7:0]);
    if (x <= 12) begin
      for (int b = 0; b < 8; b++) if (!legal(d[b*8 +: 8])) return 1;
      return 0;
    end
    if (x % 2 == 1) return d[10:0] != 0 || (d >> PA) != 0;
    return !legal(d[7:0]) || d[11:8] != 0 || (d >> PA) != 0;
  endfunction

  function automatic logic [63:0] model_read(int x);
    if (!mapped(x)) return 0;
    if (x == 0) return 64'h500 + NV;
    if (x == 1) return m_def;
    if (x <= 12) return m_fix[x-2];
    if (x % 2 == 1) return m_mask[(x-16)/2] & LOWM;
    return m_base[(x-16)/2];
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    check("R2", "mt_enable", 64'(mt_enable), 64'(m_def[11]));
    check("R2", "fixed_enable", 64'(fixed_enable), 64'(m_def[10]));
    check("R2", "default_type", 64'(default_type), 64'(m_def[7:0]));
    for (int k = 0; k < 11; k++) check("R3", "fixed_types", fixed_types[k*64 +: 64], m_fix[k]);
    for (int p = 0; p < NV; p++) begin
      check("R4", "var_base", var_base[p*64 +: 64], m_base[p]);
      check("R9", "var_mask", var_mask[p*64 +: 64], m_mask[p]);
      check("R6", "var_valid", 64'(var_valid[p]), 64'(m_mask[p][11]));
    end
  end

  task automatic acc(bit w, bit r, int x, logic [63:0] d, string req);
    bit e_err;
    logic [63:0] e_rd;
    wr_en = w; rd_en = r; addr = 6'(x); wdata = d;
    e_err = (w || r) && !mapped(x) || (w && mapped(x) && refused(x, d));
    e_rd  = r ? model_read(x) : 64'd0;
    @(negedge clk);
    check(req, "err", 64'(err), 64'(e_err));
    check(req, "rdata", rdata, e_rd);
    @(posedge clk);
    if (w && !e_err) begin
      if (x == 1) m_def = d;
      else if (x <= 12) m_fix[x-2] = d;
      else if (x % 2 == 1) m_mask[(x-16)/2] = d | ~LOWM;
      else m_base[(x-16)/2] = d;
    end
    #1;
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_def = 0;
    for (int k = 0; k < 11; k++) m_fix[k] = 0;
    for (int p = 0; p < NV; p++) begin m_base[p] = 0; m_mask[p] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    live = 1;
    for (int x = 0; x < 32; x++) acc(0, 1, x, 0, "R11");
    acc(0, 1, 0, 0, "R8");
    acc(1, 0, 0, 64'h123, "R8");
    acc(1, 0, 1, 64'hC06, "R2");
    acc(0, 1, 1, 0, "R2");
    acc(1, 0, 1, 64'h1C06, "R10");
    acc(1, 0, 1, 64'h402, "R1");
    acc(1, 0, 1, 64'h403, "R1");
    acc(1, 0, 1, 64'h407, "R1");
    acc(1, 0, 1, 64'h408, "R1");
    acc(1, 0, 1, 64'h805, "R2");
    acc(1, 0, 1, 64'h900, "R2");
    acc(1, 0, 2, 64'h0605040100010406, "R3");
    acc(1, 0, 12, 64'h0101010101010101, "R3");
    acc(1, 0, 2, 64'h0003000000000000, "R3");
    acc(1, 0, 12, 64'h0800000000000000, "R3");
    acc(0, 1, 2, 0, "R3");
    acc(0, 1, 12, 0, "R3");
    acc(1, 0, 16, 64'h000000FF12345006, "R5");
    acc(1, 0, 16, 64'h106, "R5");
    acc(1, 0, 16, 64'h2, "R5");
    acc(1, 0, 16, 64'h0000010000000006, "R7");
    acc(1, 0, 16, 64'h0000008000000006, "R7");
    acc(1, 0, 17, 64'h000000FFFFFFF800, "R6");
    acc(0, 1, 17, 0, "R9");
    acc(1, 0, 17, 64'h000001FFFFFFF800, "R7");
    acc(1, 0, 17, 64'h000000FFFFFFF801, "R6");
    acc(1, 0, 17, 64'h000000FFFFFFF400, "R6");
    acc(1, 0, 30, 64'h0000000080000001, "R4");
    acc(1, 0, 31, 64'h000000FF80000800, "R4");
    acc(0, 1, 30, 0, "R4");
    acc(0, 1, 31, 0, "R9");
    acc(1, 0, 31, 64'h000000FF80000000, "R6");
    for (int x = 13; x < 16; x++) acc(1, 1, x, 64'h6, "R11");
    acc(1, 0, 32, 64'h6, "R11");
    acc(0, 1, 63, 0, "R11");
    acc(1, 0, 5, 64'h0506070605060506, "R10");
    for (int x = 0; x < 32; x++) acc(0, 1, x, 0, "R10");
    live = 0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule